// File: doc/BRIEF.md
# Cascadable Dual-Byte Event Counter

This block counts rising edges on an external event pin that is not related to the system clock. The pin is first brought into the clock domain by a two-stage synchronizer. A third flop then turns each rising edge into a single one-cycle count pulse. The count is held in two 8-bit halves, low and high. When the mode bit is clear, which is its reset value, the halves form one 16-bit counter: the carry out of the low half advances the high half. When the mode bit is set, each half counts every event on its own.

Software controls the block through a small register port. Each half has its own count enable and its own run/hold control. Two sticky overflow flags are provided. An interrupt-request flag is set when the 16-bit counter wraps, and a separate enable bit gates it onto the interrupt output. The normal bring-up order is as follows: select 16-bit mode, drop the enables and run controls, clear both overflow flags, then raise the enables and run controls.

Top module: `event_cascade_counter`

## Requirements
- R1: After reset, every register reads 0. Both halves read 0x00, the block is in 16-bit mode, all flags are 0 and `irq_o` is 0.
- R2: While a half's run bit is 0 that half is held at 0x00 and ignores events. When the run bit is 1 the half counts. In the control register (address 0), bit 3 is the low run bit and bit 4 is the high run bit.
- R3: A half advances only while its enable bit is 1. Bit 1 is the low enable and bit 2 is the high enable. A disabled high half also ignores the carry from the low half.
- R4: One rising edge of `evt_in` gives exactly one increment, however long the pin stays high. The new count becomes readable after the third rising clock edge at which the pin has been sampled high.
- R5: In 16-bit mode (control bit 0 = 0), the low half rolling from 0xFF to 0x00 advances the high half by one. For example, 0x00FA plus 10 events gives low 0x04 and high 0x01.
- R6: In 16-bit mode, an event at 0xFFFF gives 0x0000 in both halves. The high overflow flag (control bit 6) is set, the low overflow flag (control bit 5) is unchanged, and counting continues.
- R7: The 16-bit wrap sets the interrupt-request flag (address 3, bit 0). `irq_o` is 1 only while that flag and the interrupt enable (address 3, bit 1) are both 1.
- R8: Overflow flags and the request flag stay set until software writes 0 to them. Writing 1 leaves them unchanged. A set in the same cycle as a clearing write wins.
- R9: In split mode (control bit 0 = 1), each half counts every event on its own. A low wrap sets the low overflow flag and a high wrap sets the high overflow flag. Neither sets the request flag.
- R10: Address 1 reads the low half and address 2 reads the high half. Writes to these addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 1 | Asynchronous event pin |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational on addr) |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` change only with the system clock. They also assume that every high or low level on `evt_in` lasts at least two clocks, so the synchronizer sees each level. The bench drives all inputs at the falling clock edge and holds each event level for three clocks. The 0xFFFF corner is reached without 65535 events: both halves are counted up to 0xFF in split mode, and the block then switches back to 16-bit mode. Another test times a clearing write into the exact cycle in which the wrap registers.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 2'd2;
    localparam logic [ADDR_W-1:0] A_IRQ    = 2'd3;

    // Control bit positions
    localparam int B_SPLIT  = 0;
    localparam int B_LO_EN  = 1;
    localparam int B_HI_EN  = 2;
    localparam int B_LO_RUN = 3;
    localparam int B_HI_RUN = 4;
    localparam int B_OVF_LO = 5;
    localparam int B_OVF_HI = 6;
    localparam int B_IFLAG  = 0;
    localparam int B_IEN    = 1;

    typedef struct packed {
        logic split;
        logic lo_en;
        logic hi_en;
        logic lo_run;
        logic hi_run;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic ovf_lo;
        logic ovf_hi;
        logic irq_flag;
        logic irq_en;
    } regs_t;
endpackage

// File: rtl/ecc_event_sync.sv
module ecc_event_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_async,
    output logic evt_pulse
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[CHAIN-2:0], evt_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign evt_pulse = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R4: an edge yields a single-cycle pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |=> !evt_pulse);
endmodule

// File: rtl/ecc_half.sv
module ecc_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         en,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         carry
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        carry = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (en && inc) begin
            cnt_d = cnt_q + 1'b1;
            carry = (cnt_q == MAXV);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    a_r2_held_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

    a_r3_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !en) |=> $stable(cnt_q));
endmodule

// File: rtl/event_cascade_counter.sv
module event_cascade_counter
    import ecc_pkg::*;
#(
    parameter int HALF_W    = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    output logic              irq_o
);
    localparam int NHALF = 2;

    logic              evt_pulse;
    logic [NHALF-1:0]  h_inc, h_en, h_run, h_carry;
    logic [HALF_W-1:0] h_cnt [NHALF];
    logic              wrap16;
    regs_t             r_d, r_q;

    ecc_event_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_async (evt_in),
        .evt_pulse (evt_pulse)
    );

    assign h_inc[0] = evt_pulse;
    assign h_inc[1] = r_q.cfg.split ? evt_pulse : h_carry[0];
    assign h_en     = {r_q.cfg.hi_en,  r_q.cfg.lo_en};
    assign h_run    = {r_q.cfg.hi_run, r_q.cfg.lo_run};

    for (genvar g = 0; g < NHALF; g++) begin : g_half
        ecc_half #(.W(HALF_W)) u_half (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (h_run[g]),
            .en    (h_en[g]),
            .inc   (h_inc[g]),
            .cnt   (h_cnt[g]),
            .carry (h_carry[g])
        );
    end

    assign wrap16 = !r_q.cfg.split && h_carry[1];

    always_comb begin
        r_d = r_q;
        if (wr_en && addr == A_CTRL) begin
            r_d.cfg.split  = wdata[B_SPLIT];
            r_d.cfg.lo_en  = wdata[B_LO_EN];
            r_d.cfg.hi_en  = wdata[B_HI_EN];
            r_d.cfg.lo_run = wdata[B_LO_RUN];
            r_d.cfg.hi_run = wdata[B_HI_RUN];
            if (!wdata[B_OVF_LO]) r_d.ovf_lo = 1'b0;
            if (!wdata[B_OVF_HI]) r_d.ovf_hi = 1'b0;
        end
        if (wr_en && addr == A_IRQ) begin
            if (!wdata[B_IFLAG]) r_d.irq_flag = 1'b0;
            r_d.irq_en = wdata[B_IEN];
        end
        // set events override clears
        if (r_q.cfg.split && h_carry[0]) r_d.ovf_lo   = 1'b1;
        if (h_carry[1])                  r_d.ovf_hi   = 1'b1;
        if (wrap16)                      r_d.irq_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[B_SPLIT]  = r_q.cfg.split;
                rdata[B_LO_EN]  = r_q.cfg.lo_en;
                rdata[B_HI_EN]  = r_q.cfg.hi_en;
                rdata[B_LO_RUN] = r_q.cfg.lo_run;
                rdata[B_HI_RUN] = r_q.cfg.hi_run;
                rdata[B_OVF_LO] = r_q.ovf_lo;
                rdata[B_OVF_HI] = r_q.ovf_hi;
            end
            A_CNT_LO: rdata = h_cnt[0];
            A_CNT_HI: rdata = h_cnt[1];
            default: begin
                rdata[B_IFLAG] = r_q.irq_flag;
                rdata[B_IEN]   = r_q.irq_en;
            end
        endcase
    end

    assign irq_o = r_q.irq_flag & r_q.irq_en;

    // R6: a 16-bit wrap only starts from an all-ones count
    a_r6_wrap_from_max: assert property (@(posedge clk) disable iff (!rst_n)
        wrap16 |-> (h_cnt[0] == '1 && h_cnt[1] == '1));

    a_r6_ovf_hi_set: assert property (@(posedge clk) disable iff (!rst_n)
        wrap16 |=> r_q.ovf_hi);

    // R7: the request flag rises only after a 16-bit wrap
    a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.irq_flag) |-> $past(wrap16));

    // R8: high overflow flag is sticky without a clearing write
    a_r8_sticky_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ovf_hi && !(wr_en && addr == A_CTRL && !wdata[B_OVF_HI])) |=> r_q.ovf_hi);

    // R9: split mode never raises the request flag
    a_r9_split_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cfg.split && !r_q.irq_flag) |=> !r_q.irq_flag);
endmodule

// File: tb/sim_event_cascade_counter.sv
`timescale 1ns/1ps
module sim_event_cascade_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    event_cascade_counter u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    // {ctrl, events, exp_lo, exp_hi}; walked in order, counts accumulate
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV] = '{
        {8'h1E, 8'd5,   8'h05, 8'h00},   // R4 basic counting
        {8'h06, 8'd3,   8'h00, 8'h00},   // R2 run bits 0 hold at zero
        {8'h1C, 8'd4,   8'h00, 8'h00},   // R3 low enable off
        {8'h1E, 8'd250, 8'hFA, 8'h00},   // R5 approach carry
        {8'h1E, 8'd10,  8'h04, 8'h01},   // R5 carry into high
        {8'h1F, 8'd3,   8'h07, 8'h04},   // R9 split independent
        {8'h1A, 8'd252, 8'h03, 8'h04}    // R3 high disabled ignores carry
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic pulse_evt(input int n);
        for (int i = 0; i < n; i++) begin
            evt_in = 1'b1;
            repeat (3) @(negedge clk);
            evt_in = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [7:0] v, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, v); check("R1 lo", v, 8'h00);
        rd(2'd2, v); check("R1 hi", v, 8'h00);
        rd(2'd3, v); check("R1 irq", v, 8'h00);
        check("R1 irq_o", {7'd0, irq_o}, 8'h00);

        // vector table
        for (int k = 0; k < NV; k++) begin
            wr(2'd0, VEC[k][31:24]);
            pulse_evt(int'(VEC[k][23:16]));
            rd(2'd1, v); check($sformatf("vec%0d lo", k), v, VEC[k][15:8]);
            rd(2'd2, v); check($sformatf("vec%0d hi", k), v, VEC[k][7:0]);
        end

        // R10 writes to count addresses ignored
        wr(2'd1, 8'h55); wr(2'd2, 8'hAA);
        rd(2'd1, v); check("R10 lo write ignored", v, 8'h03);
        rd(2'd2, v); check("R10 hi write ignored", v, 8'h04);

        // R4 level held counts once; latency of three edges
        wr(2'd0, 8'h1E);
        rd(2'd1, base);
        @(negedge clk); evt_in = 1'b1;
        @(posedge clk); rd(2'd1, v); check("R4 edge1 no change", v, base);
        rd(2'd1, v); check("R4 edge2 no change", v, base);
        rd(2'd1, v); check("R4 edge3 incremented", v, base + 8'd1);
        repeat (20) @(negedge clk);
        rd(2'd1, v); check("R4 held level single count", v, base + 8'd1);
        evt_in = 1'b0; repeat (3) @(negedge clk);

        // R6/R7 wrap: clear, fill both halves in split mode, rejoin
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h1F);
        pulse_evt(255);
        wr(2'd0, 8'h1E);
        wr(2'd3, 8'h00);
        pulse_evt(1);
        rd(2'd1, v); check("R6 lo wraps", v, 8'h00);
        rd(2'd2, v); check("R6 hi wraps", v, 8'h00);
        rd(2'd0, v); check("R6 ovf_hi set ovf_lo clear", v & 8'h60, 8'h40);
        rd(2'd3, v); check("R7 flag set", v, 8'h01);
        check("R7 irq_o gated off", {7'd0, irq_o}, 8'h00);
        wr(2'd3, 8'h03);
        @(negedge clk);
        check("R7 irq_o enabled", {7'd0, irq_o}, 8'h01);

        // R8 sticky, write-0 clears
        wr(2'd0, 8'h5E);
        rd(2'd0, v); check("R8 write 1 keeps ovf_hi", v & 8'h40, 8'h40);
        wr(2'd0, 8'h1E);
        rd(2'd0, v); check("R8 write 0 clears ovf_hi", v & 8'h40, 8'h00);
        wr(2'd3, 8'h02);
        rd(2'd3, v); check("R8 flag cleared", v, 8'h02);
        check("R8 irq_o low after clear", {7'd0, irq_o}, 8'h00);

        // R9 split wraps set own flags, no request
        wr(2'd0, 8'h1F);
        pulse_evt(256);
        rd(2'd1, v); check("R9 lo wrapped", v, 8'h00);
        rd(2'd2, v); check("R9 hi wrapped", v, 8'h00);
        rd(2'd0, v); check("R9 both ovf flags", v & 8'h60, 8'h60);
        rd(2'd3, v); check("R9 no request flag", v, 8'h02);

        // R8 set beats same-cycle clear
        wr(2'd0, 8'h1E);
        wr(2'd0, 8'h1F);
        pulse_evt(255);
        wr(2'd0, 8'h1E);
        @(negedge clk); evt_in = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b1; addr = 2'd0; wdata = 8'h1E;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        evt_in = 1'b0; repeat (3) @(negedge clk);
        rd(2'd0, v); check("R8 set wins over clear", v & 8'h40, 8'h40);
        rd(2'd2, v); check("R8 hi wrapped", v, 8'h00);
        rd(2'd3, v); check("R7 flag on timed wrap", v, 8'h03);

        finish_run();
    end
endmodule